// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block sits beside the fetch stage of a 32-bit processor and decides the address of the next instruction. Decode hands it the current PC, a small control-transfer code, the 16-bit branch displacement, the 26-bit jump target field and the two register operands. The block returns the next PC and a flag telling fetch that the sequential path was left. For jump-and-link transfers it also returns a link write request. The link value is always the return address PC + 4 and goes to general register 31.

Branches cover two kinds of test. One kind compares the two operands for equality or inequality. The other kind compares the first operand alone against zero as a signed number. Direct jumps keep the top four bits of the PC and splice the target field below them. Register jumps take the operand as the new PC and flag a misaligned address. The path is purely combinational by default. A parameter adds a PC register that loads the computed value on every clock and resets to a chosen vector.

Top module: `npc_unit`

## Requirements
- R1: The transfer code `xfer_i` is 0 for no transfer. Codes 11 to 15 are unused and behave the same as 0. In both cases `npc_o` = PC + 4, and `taken_o`, `link_we_o` and `addr_err_o` are all 0.
- R2: A taken branch gives `npc_o` = PC + 4 + (sign-extended displacement × 4), with all arithmetic modulo 2^32.
- R3: A branch whose condition fails gives `npc_o` = PC + 4 and `taken_o` = 0.
- R4: Code 1 (equal) is taken when `rs_val_i` == `rt_val_i` over all 32 bits. Code 2 (not equal) is taken when they differ.
- R5: Codes 3, 4, 5 and 6 test `rs_val_i` as a signed value against zero: 3 for >= 0, 4 for <= 0, 5 for < 0 and 6 for > 0. `rt_val_i` has no effect on these codes.
- R6: Codes 7 (jump) and 9 (jump and link) give `npc_o` = {PC[31:28], `jtgt_i`, 2'b00}.
- R7: Codes 8 (register jump) and 10 (register jump and link) give `npc_o` = `rs_val_i`, unchanged.
- R8: `taken_o` is 1 for every jump code (7 to 10), and for a branch only when its condition holds.
- R9: `link_we_o` is 1 only for codes 9 and 10. `link_val_o` always equals PC + 4, modulo 2^32.
- R10: `addr_err_o` is 1 only for codes 8 and 10 when `rs_val_i[1:0]` is not 00.
- R11: With `PC_REG` = 1, `npc_o` is a register. It holds `RESET_PC` while `rst_ni` is low, and after each rising clock edge it holds the value computed before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; used by the optional PC register and the checks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_i | input | 32 | Address of the current instruction |
| xfer_i | input | 4 | Control-transfer code |
| disp_i | input | 16 | Signed branch displacement, in words |
| jtgt_i | input | 26 | Direct jump target field |
| rs_val_i | input | 32 | First register operand |
| rt_val_i | input | 32 | Second register operand |
| npc_o | output | 32 | Next PC |
| taken_o | output | 1 | Sequential path left |
| link_we_o | output | 1 | Write link value to register 31 |
| link_val_o | output | 32 | Return address PC + 4 |
| addr_err_o | output | 1 | Register jump target not word-aligned |

## Verification
On every cycle, the assertions check several invariants:
- A result that is not taken always goes to PC + 4.
- A direct jump keeps the PC's top nibble and is word-aligned.
- A link request is always taken and carries PC + 4.
- An address error only accompanies a taken PC with a misaligned low pair.
- The registered variant tracks the combinational value one edge late.

Some behaviour only the bench scenarios can show:
- The exact branch target arithmetic, including wrap past the top of the address space and the extreme displacements.
- The signed zero boundaries at 0 and 0x80000000.
- That `rt_val_i` has no effect on zero compares.
- The reset vector of the registered PC.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XFER_W = 4;

  typedef enum logic [XFER_W-1:0] {
    XF_NONE  = 4'd0,
    XF_BEQ   = 4'd1,
    XF_BNE   = 4'd2,
    XF_BGEZ  = 4'd3,
    XF_BLEZ  = 4'd4,
    XF_BLTZ  = 4'd5,
    XF_BGTZ  = 4'd6,
    XF_JDIR  = 4'd7,
    XF_JREG  = 4'd8,
    XF_JLDIR = 4'd9,
    XF_JLREG = 4'd10
  } xfer_e;

  function automatic logic is_branch(input logic [XFER_W-1:0] x);
    return (x >= XF_BEQ) && (x <= XF_BGTZ);
  endfunction

  function automatic logic is_jump(input logic [XFER_W-1:0] x);
    return (x >= XF_JDIR) && (x <= XF_JLREG);
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [XFER_W-1:0] xfer_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  output logic              cond_o
);
  logic eq, neg, zero;

  assign eq   = (a_i == b_i);
  assign neg  = a_i[W-1];
  assign zero = (a_i == '0);

  always_comb begin
    unique case (xfer_e'(xfer_i))
      XF_BEQ:  cond_o = eq;
      XF_BNE:  cond_o = !eq;
      XF_BGEZ: cond_o = !neg;
      XF_BLEZ: cond_o = neg || zero;
      XF_BLTZ: cond_o = neg;
      XF_BGTZ: cond_o = !neg && !zero;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int W      = 32,
  parameter int DISP_W = 16,
  parameter int JT_W   = 26
) (
  input  logic [W-1:0]      pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [JT_W-1:0]   jtgt_i,
  output logic [W-1:0]      seq_o,
  output logic [W-1:0]      br_tgt_o,
  output logic [W-1:0]      jdir_tgt_o
);
  localparam int EXT_W = W - DISP_W - 2;
  localparam int HI_W  = W - JT_W - 2;

  logic [W-1:0] disp_ext;

  assign seq_o      = pc_i + W'(4);
  assign disp_ext   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 2'b00};
  assign br_tgt_o   = seq_o + disp_ext;
  assign jdir_tgt_o = {pc_i[W-1 -: HI_W], jtgt_i, 2'b00};
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          W        = 32,
  parameter int          DISP_W   = 16,
  parameter int          JT_W     = 26,
  parameter bit          PC_REG   = 1'b0,
  parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      pc_i,
  input  logic [XFER_W-1:0] xfer_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [JT_W-1:0]   jtgt_i,
  input  logic [W-1:0]      rs_val_i,
  input  logic [W-1:0]      rt_val_i,
  output logic [W-1:0]      npc_o,
  output logic              taken_o,
  output logic              link_we_o,
  output logic [W-1:0]      link_val_o,
  output logic              addr_err_o
);
  localparam int HI_W = W - JT_W - 2;

  logic [W-1:0] seq, br_tgt, jdir_tgt, npc_comb;
  logic         cond_ok;
  xfer_e        xf;

  assign xf = xfer_e'(xfer_i);

  npc_cond #(.W(W)) u_cond (
    .xfer_i (xfer_i),
    .a_i    (rs_val_i),
    .b_i    (rt_val_i),
    .cond_o (cond_ok)
  );

  npc_target #(.W(W), .DISP_W(DISP_W), .JT_W(JT_W)) u_tgt (
    .pc_i       (pc_i),
    .disp_i     (disp_i),
    .jtgt_i     (jtgt_i),
    .seq_o      (seq),
    .br_tgt_o   (br_tgt),
    .jdir_tgt_o (jdir_tgt)
  );

  always_comb begin
    npc_comb = seq;
    unique case (xf)
      XF_JDIR, XF_JLDIR: npc_comb = jdir_tgt;
      XF_JREG, XF_JLREG: npc_comb = rs_val_i;
      default: if (is_branch(xfer_i) && cond_ok) npc_comb = br_tgt;
    endcase
  end

  assign taken_o    = is_jump(xfer_i) || (is_branch(xfer_i) && cond_ok);
  assign link_we_o  = (xf == XF_JLDIR) || (xf == XF_JLREG);
  assign link_val_o = seq;
  assign addr_err_o = ((xf == XF_JREG) || (xf == XF_JLREG)) && (rs_val_i[1:0] != 2'b00);

  generate
    if (PC_REG) begin : g_reg
      logic [W-1:0] pc_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pc_q <= W'(RESET_PC);
        else         pc_q <= npc_comb;
      end
      assign npc_o = pc_q;

      p_reg_track_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> npc_o == $past(npc_comb));
    end else begin : g_comb
      assign npc_o = npc_comb;
    end
  endgenerate

  p_seq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> npc_comb == pc_i + W'(4));

  p_jdir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xf == XF_JDIR || xf == XF_JLDIR) |->
      (npc_comb[W-1 -: HI_W] == pc_i[W-1 -: HI_W]) && (npc_comb[1:0] == 2'b00));

  p_link_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> taken_o && (link_val_o == pc_i + W'(4)));

  p_err_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> taken_o && (npc_comb[1:0] != 2'b00));

  p_eq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xf == XF_BEQ && rs_val_i == rt_val_i) |-> taken_o);

  p_none_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i == '0 || xfer_i > 4'd10) |-> !taken_o && !link_we_o && !addr_err_o);
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  localparam logic [31:0] RST_VEC = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc, rs, rt;
  logic [3:0]  xf;
  logic [15:0] disp;
  logic [25:0] jt;
  logic [31:0] npc0, lval0, npc1, lval1;
  logic        tk0, lwe0, err0, tk1, lwe1, err1;

  int checks = 0;
  int errors = 0;
  logic [31:0] prev_npc;
  logic        have_prev = 1'b0;

  always #4 clk = ~clk;

  npc_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .xfer_i(xf), .disp_i(disp), .jtgt_i(jt),
    .rs_val_i(rs), .rt_val_i(rt), .npc_o(npc0), .taken_o(tk0), .link_we_o(lwe0),
    .link_val_o(lval0), .addr_err_o(err0)
  );

  npc_unit #(.PC_REG(1'b1), .RESET_PC(RST_VEC)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .pc_i(pc), .xfer_i(xf), .disp_i(disp), .jtgt_i(jt),
    .rs_val_i(rs), .rt_val_i(rt), .npc_o(npc1), .taken_o(tk1), .link_we_o(lwe1),
    .link_val_o(lval1), .addr_err_o(err1)
  );

  function automatic void model(input logic [3:0] x, input logic [31:0] p, a, b,
                                input logic [15:0] d, input logic [25:0] t,
                                output logic [31:0] n, output logic tk, lw, er);
    logic [31:0] s, br;
    logic c;
    s  = p + 32'd4;
    br = s + ({{16{d[15]}}, d} << 2);
    case (x)
      4'd1: c = (a == b);
      4'd2: c = (a != b);
      4'd3: c = ($signed(a) >= 0);
      4'd4: c = ($signed(a) <= 0);
      4'd5: c = ($signed(a) < 0);
      4'd6: c = ($signed(a) > 0);
      default: c = 1'b0;
    endcase
    n = s; tk = 1'b0; lw = 1'b0; er = 1'b0;
    if (x >= 4'd1 && x <= 4'd6 && c) begin n = br; tk = 1'b1; end
    if (x == 4'd7 || x == 4'd9) begin n = {p[31:28], t, 2'b00}; tk = 1'b1; end
    if (x == 4'd8 || x == 4'd10) begin n = a; tk = 1'b1; er = (a[1:0] != 2'b00); end
    lw = (x == 4'd9 || x == 4'd10);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] x);
    case (x)
      4'd1, 4'd2: return "R4";
      4'd3, 4'd4, 4'd5, 4'd6: return "R5";
      4'd7, 4'd9: return "R6";
      4'd8, 4'd10: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [3:0] x, input logic [31:0] p, a, b,
                       input logic [15:0] d, input logic [25:0] t);
    logic [31:0] en;
    logic et, el, ee;
    @(negedge clk);
    xf = x; pc = p; rs = a; rt = b; disp = d; jt = t;
    #2;
    if (have_prev) chk("R11", "registered npc", npc1, prev_npc);
    model(x, p, a, b, d, t, en, et, el, ee);
    chk(req_of(x), "npc", npc0, en);
    chk(et ? "R8" : "R3", "taken", {31'd0, tk0}, {31'd0, et});
    chk("R9", "link_we", {31'd0, lwe0}, {31'd0, el});
    chk("R9", "link_val", lval0, p + 32'd4);
    chk("R10", "addr_err", {31'd0, err0}, {31'd0, ee});
    if (x >= 4'd1 && x <= 4'd6 && et) chk("R2", "branch target", npc0, p + 32'd4 + ({{16{d[15]}}, d} << 2));
    prev_npc  = en;
    have_prev = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1337));
    xf = 4'd0; pc = 32'h0040_0000; rs = '0; rt = '0; disp = '0; jt = '0;
    repeat (3) @(negedge clk);
    #2;
    chk("R11", "reset vector", npc1, RST_VEC);
    chk("R1", "reset idle taken", {31'd0, tk0}, 32'd0);
    chk("R1", "reset idle npc", npc0, 32'h0040_0004);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R11", "first load after reset", npc1, 32'h0040_0004);

    // R1 unused codes
    for (int c = 11; c < 16; c++) apply(4'(c), 32'h1000_0000, 32'h3, 32'h3, 16'h0010, 26'h1);
    apply(4'd0, 32'h1234_5678, 32'h5, 32'h5, 16'hFFFF, 26'h3FF_FFFF);
    // R2 extreme displacements and wrap
    apply(4'd1, 32'h0000_1000, 32'h7, 32'h7, 16'h7FFF, '0);
    apply(4'd1, 32'h0004_0000, 32'h7, 32'h7, 16'h8000, '0);
    apply(4'd1, 32'h0000_0100, 32'h7, 32'h7, 16'hFFFF, '0);
    apply(4'd2, 32'hFFFF_FFFC, 32'h1, 32'h2, 16'h0001, '0);
    // R4 equality differs only in the top bit
    apply(4'd1, 32'h100, 32'h8000_0000, 32'h0, 16'h4, '0);
    apply(4'd2, 32'h100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 16'h4, '0);
    // R5 signed zero boundaries; rt must not matter
    for (int c = 3; c <= 6; c++) begin
      apply(4'(c), 32'h200, 32'h0, 32'h0, 16'h10, '0);
      apply(4'(c), 32'h200, 32'h0, 32'hFFFF_FFFF, 16'h10, '0);
      apply(4'(c), 32'h200, 32'h8000_0000, 32'h8000_0000, 16'h10, '0);
      apply(4'(c), 32'h200, 32'h7FFF_FFFF, 32'h0, 16'h10, '0);
      apply(4'(c), 32'h200, 32'h1, 32'h1, 16'h10, '0);
    end
    // R6 top nibble kept
    apply(4'd7, 32'hA000_0010, '0, '0, '0, 26'h0000475);
    apply(4'd9, 32'hF7FF_FFFC, '0, '0, '0, 26'h3FF_FFFF);
    // R7 and R10 aligned and misaligned register jumps
    apply(4'd8, 32'h400, 32'h0040_1000, '0, '0, '0);
    apply(4'd8, 32'h400, 32'h0040_1002, '0, '0, '0);
    apply(4'd10, 32'h400, 32'h0040_1001, '0, '0, '0);
    apply(4'd10, 32'hFFFF_FFFC, 32'h8000_0000, '0, '0, '0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom % 4 == 0) ? a : $urandom;
      if ($urandom % 8 == 0) a = '0;
      apply(4'($urandom % 16), $urandom, a, b, 16'($urandom), 26'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule